// File: doc/BRIEF.md
# Receive Queue with Per-Character Error Tags

This block sits between a serial receiver's shift register and the bus-facing register file of a UART. Each character that the receiver assembles is written into a small first-in first-out queue, together with three error flags for that character: break, framing and parity. The queue stores a fourth flag beside them, overrun, which it generates itself. The tags travel with their character. Software reading the queue therefore sees exactly which character was damaged. It reads the tag view of the oldest entry first and then takes the data byte, and taking the data byte is what removes the entry.

The queue reports its fill level in a split form: a count field as wide as the address, plus a separate full flag. When the queue is completely full, the count field wraps to zero and only the full flag is set. Three sticky interrupt flags are available, each cleared by writing 1:
- a receive flag, raised when the fill level reaches a programmable trigger level;
- an error flag, raised when a tagged character is stored;
- a timeout flag, raised when the line stays idle for a set number of bit periods, even when the queue is empty.

A synchronous clear input empties the queue. Dropping the receive enable has the same effect and also holds the idle timer at zero.

Top module: `rxq_tagged_fifo`

## Requirements
- R1: The status is the pair {stat_full, stat_cnt}. The true number of held entries equals stat_cnt + 16*stat_full. When the queue holds 16 entries, stat_full is 1 and stat_cnt is 0.
- R2: head_data and head_err always show the oldest entry. A pop strobe removes that entry. A pop while the queue is empty changes nothing.
- R3: Every entry keeps its own tag nibble, laid out as head_err[3]=break, [2]=framing, [1]=parity, [0]=overrun. The break, framing and parity bits are copied from the write that stored the entry.
- R4: A write while the queue is full discards the character, leaves the fill level at 16, and marks an overrun as pending. The pending overrun appears as head_err[0]=1 on the next character that is stored, and is then cleared.
- R5: trig_sel values 0, 1, 2 and 3 select trigger levels of 4, 8, 12 and 16 entries. irq_rx is set on the clock edge after the fill level is at or above the selected level.
- R6: irq_err is set on the same clock edge that stores an entry whose tag nibble is nonzero.
- R7: Count bit_tick pulses while rx_idle is high and no character is written. irq_tout is set on the edge of the 32nd such pulse, whether or not the queue holds entries. A write, or rx_idle going low, restarts the count.
- R8: irq_rx, irq_err and irq_tout stay set until a 1 is written to clr_irq[0], clr_irq[1] or clr_irq[2] respectively. If the set condition is present in the same cycle as the clear, the set condition wins.
- R9: A pulse on fifo_clr empties the queue and drops any pending overrun.
- R10: While rx_enable is low, the queue is held empty, writes are ignored, and the idle timer does not advance.
- R11: After reset, the queue is empty, no overrun is pending, and all three interrupt flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_enable | input | 1 | Receive mode enable; low flushes the queue and stops the timer |
| fifo_clr | input | 1 | Synchronous queue clear pulse |
| trig_sel | input | 2 | Trigger level code (0..3 gives 4, 8, 12, 16 entries) |
| wr_en | input | 1 | Character write strobe from the shift register |
| wr_data | input | 8 | Received character |
| wr_brk | input | 1 | Break detected on this character |
| wr_frm | input | 1 | Framing error on this character |
| wr_par | input | 1 | Parity error on this character |
| bit_tick | input | 1 | One pulse per bit period |
| rx_idle | input | 1 | Receiver line idle |
| pop | input | 1 | Remove the oldest entry |
| head_data | output | 8 | Data byte of the oldest entry |
| head_err | output | 4 | Tag nibble of the oldest entry |
| stat_cnt | output | 4 | Fill level modulo 16 |
| stat_full | output | 1 | Queue holds 16 entries |
| irq_rx | output | 1 | Sticky trigger-level flag |
| irq_err | output | 1 | Sticky error flag |
| irq_tout | output | 1 | Sticky idle-timeout flag |
| clr_irq | input | 3 | Write-1-to-clear for rx, err, tout flags |

## Verification
A wrong read or write pointer shows on head_data or head_err at the very next pop. It surfaces as a character that is out of order or carries the wrong tag. A corrupted level counter shows in the same cycle on {stat_full, stat_cnt}, and one cycle later it moves irq_rx at the wrong fill level. A lost or misplaced pending overrun appears only when the following character reaches the head. For that reason the scoreboard compares every popped entry, including the first one stored after an overflow or a clear. A timer that is off by one moves the irq_tout edge by one tick, so the bench samples the flag at the tick just before the 32nd and again at the 32nd.

// File: rtl/rxq_pkg.sv
// Shared definitions for the tagged receive queue.
// Assumes nothing beyond a packed four-bit tag per character.
package rxq_pkg;
    // Per-character status nibble, bit 3 down to bit 0.
    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
        logic ovr;
    } rxq_tag_t;

    localparam int TAG_W = 4;
endpackage

// File: rtl/rxq_store.sv
// Storage and pointer logic for the tagged receive queue.
// Holds DEPTH characters, each with its own tag nibble, and tracks a
// pending overrun that is attached to the next stored character.
// Assumes DEPTH is a power of two, so the pointers wrap naturally.
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          wr_req,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_brk,
    input  logic          wr_frm,
    input  logic          wr_par,
    input  logic          rd_pop,
    output logic [DW-1:0] head_data,
    output rxq_tag_t      head_tag,
    output logic [CW-1:0] level,
    output logic          store_evt,
    output rxq_tag_t      store_tag
);
    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

    logic [DW-1:0] dmem [DEPTH];
    rxq_tag_t      tmem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          pend_ovr;
    logic          is_full, is_empty, do_store, do_drop, do_pop;

    assign is_full   = (level == FULL_LVL);
    assign is_empty  = (level == '0);
    assign do_store  = wr_req & ~is_full & ~flush;
    assign do_drop   = wr_req & is_full & ~flush;
    assign do_pop    = rd_pop & ~is_empty & ~flush;
    assign store_evt = do_store;
    assign store_tag = '{brk: wr_brk, frm: wr_frm, par: wr_par, ovr: pend_ovr};

    // Write the incoming character and its tag into the slot at wptr.
    always_ff @(posedge clk) begin
        if (do_store) begin
            dmem[wptr] <= wr_data;
            tmem[wptr] <= store_tag;
        end
    end

    // Advance the pointers; a flush returns both to slot zero.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (do_store) wptr <= wptr + 1'b1;
            if (do_pop)   rptr <= rptr + 1'b1;
        end
    end

    // Fill level: up one per store, down one per pop.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            level <= '0;
        end else begin
            case ({do_store, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // Pending overrun: set by a dropped write, consumed by the next store.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) pend_ovr <= 1'b0;
        else if (do_drop)    pend_ovr <= 1'b1;
        else if (do_store)   pend_ovr <= 1'b0;
    end

    assign head_data = dmem[rptr];
    assign head_tag  = tmem[rptr];
endmodule

// File: rtl/rxq_timeout.sv
// Idle timer for the receive queue.
// Counts bit periods while the line is idle and no character arrives,
// and pulses fire on the tick that completes TOUT_BITS periods.
// The count then saturates until a restart, so it fires once per idle gap.
module rxq_timeout #(
    parameter int TOUT_BITS = 32,
    localparam int TW       = $clog2(TOUT_BITS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic restart,
    input  logic tick,
    output logic fire
);
    localparam logic [TW-1:0] LAST = TW'(TOUT_BITS - 1);
    localparam logic [TW-1:0] SAT  = TW'(TOUT_BITS);

    logic [TW-1:0] cnt;

    assign fire = ~hold & ~restart & tick & (cnt == LAST);

    // Idle bit-period counter, saturating at TOUT_BITS.
    always_ff @(posedge clk) begin
        if (!rst_n || hold || restart) cnt <= '0;
        else if (tick && cnt != SAT)   cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rxq_flags.sv
// Bank of N sticky interrupt flags, each cleared by writing 1.
// If set and clear arrive in the same cycle, the set wins.
module rxq_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flag
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // One sticky bit with set priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n) flag[i] <= 1'b0;
            else        flag[i] <= set[i] | (flag[i] & ~clr[i]);
        end
    end
endmodule

// File: rtl/rxq_tagged_fifo.sv
// Receive queue with a per-character error tag, split fill status,
// a trigger-level flag, an error flag and an idle-timeout flag.
// Assumes DEPTH is a power of two, divisible by four; the four trigger
// levels are quarter steps of DEPTH.
module rxq_tagged_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int DW        = 8,
    parameter int TOUT_BITS = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rx_enable,
    input  logic                     fifo_clr,
    input  logic [1:0]               trig_sel,
    input  logic                     wr_en,
    input  logic [DW-1:0]            wr_data,
    input  logic                     wr_brk,
    input  logic                     wr_frm,
    input  logic                     wr_par,
    input  logic                     bit_tick,
    input  logic                     rx_idle,
    input  logic                     pop,
    output logic [DW-1:0]            head_data,
    output logic [TAG_W-1:0]         head_err,
    output logic [$clog2(DEPTH)-1:0] stat_cnt,
    output logic                     stat_full,
    output logic                     irq_rx,
    output logic                     irq_err,
    output logic                     irq_tout,
    input  logic [2:0]               clr_irq
);
    localparam int AW   = $clog2(DEPTH);
    localparam int CW   = AW + 1;
    localparam int STEP = DEPTH / 4;

    logic          flush, wr_ok, store_evt, tout_fire;
    logic [CW-1:0] level, thr;
    rxq_tag_t      head_tag, store_tag;
    logic [2:0]    set_vec, flag_vec;

    assign flush = fifo_clr | ~rx_enable;
    assign wr_ok = wr_en & rx_enable;

    rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .wr_req    (wr_ok),
        .wr_data   (wr_data),
        .wr_brk    (wr_brk),
        .wr_frm    (wr_frm),
        .wr_par    (wr_par),
        .rd_pop    (pop),
        .head_data (head_data),
        .head_tag  (head_tag),
        .level     (level),
        .store_evt (store_evt),
        .store_tag (store_tag)
    );

    rxq_timeout #(.TOUT_BITS(TOUT_BITS)) u_tout (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (~rx_enable | ~rx_idle),
        .restart (wr_ok),
        .tick    (bit_tick),
        .fire    (tout_fire)
    );

    // Trigger threshold in entries: (code + 1) quarter-depths.
    assign thr = CW'((32'(trig_sel) + 1) * STEP);

    assign set_vec[0] = (level >= thr);
    assign set_vec[1] = store_evt & (|store_tag);
    assign set_vec[2] = tout_fire;

    rxq_flags #(.N(3)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (set_vec),
        .clr   (clr_irq),
        .flag  (flag_vec)
    );

    assign irq_rx    = flag_vec[0];
    assign irq_err   = flag_vec[1];
    assign irq_tout  = flag_vec[2];
    assign head_err  = head_tag;
    assign stat_cnt  = level[AW-1:0];
    assign stat_full = level[AW];
endmodule

// File: rtl/rxq_tagged_fifo_chk.sv
// Port-level checker for rxq_tagged_fifo, attached by bind.
// Assumes the default depth-16 status split.
module rxq_tagged_fifo_chk #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_enable,
    input logic          fifo_clr,
    input logic          wr_en,
    input logic          pop,
    input logic [2:0]    clr_irq,
    input logic [AW-1:0] stat_cnt,
    input logic          stat_full,
    input logic          irq_rx,
    input logic          irq_err,
    input logic          irq_tout
);
    logic [AW:0] held;
    assign held = {stat_full, stat_cnt};

    AST_FULL_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        stat_full |-> (stat_cnt == '0)); // R1

    AST_POP_EMPTY_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
        (held == '0 && pop && !wr_en && rx_enable && !fifo_clr) |=> (held == '0)); // R2

    AST_FULL_WRITE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_full && wr_en && !pop && rx_enable && !fifo_clr) |=> stat_full); // R4

    AST_RX_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_rx && !clr_irq[0]) |=> irq_rx); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_err && !clr_irq[1]) |=> irq_err); // R8

    AST_TOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_tout && !clr_irq[2]) |=> irq_tout); // R8

    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> (held == '0)); // R9

    AST_DISABLE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable |=> (held == '0)); // R10
endmodule

bind rxq_tagged_fifo rxq_tagged_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_enable (rx_enable),
    .fifo_clr  (fifo_clr),
    .wr_en     (wr_en),
    .pop       (pop),
    .clr_irq   (clr_irq),
    .stat_cnt  (stat_cnt),
    .stat_full (stat_full),
    .irq_rx    (irq_rx),
    .irq_err   (irq_err),
    .irq_tout  (irq_tout)
);

// File: tb/sim_rxq_tagged_fifo.sv
// Scoreboard bench: the write task pushes expected {tag,data} items,
// the pop task compares the head against the queue front and removes it.
module sim_rxq_tagged_fifo;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_enable = 1'b1, fifo_clr = 1'b0;
    logic [1:0] trig_sel = 2'd1;
    logic       wr_en = 1'b0, wr_brk = 1'b0, wr_frm = 1'b0, wr_par = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       bit_tick = 1'b0, rx_idle = 1'b0, pop = 1'b0;
    logic [2:0] clr_irq = 3'b000;
    logic [7:0] head_data;
    logic [3:0] head_err, stat_cnt;
    logic       stat_full, irq_rx, irq_err, irq_tout;

    int checks = 0;
    int errors = 0;
    logic [11:0] sb[$];
    logic pend = 1'b0;

    always #5 clk = ~clk;

    rxq_tagged_fifo u0 (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .fifo_clr(fifo_clr),
        .trig_sel(trig_sel), .wr_en(wr_en), .wr_data(wr_data),
        .wr_brk(wr_brk), .wr_frm(wr_frm), .wr_par(wr_par),
        .bit_tick(bit_tick), .rx_idle(rx_idle), .pop(pop),
        .head_data(head_data), .head_err(head_err), .stat_cnt(stat_cnt),
        .stat_full(stat_full), .irq_rx(irq_rx), .irq_err(irq_err),
        .irq_tout(irq_tout), .clr_irq(clr_irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    // Driver: one character write, expected item pushed to the scoreboard.
    task automatic put(input logic [7:0] d, input logic b, input logic f, input logic p);
        if (rx_enable) begin
            if (sb.size() == 16) pend = 1'b1;
            else begin
                sb.push_back({b, f, p, pend, d});
                pend = 1'b0;
            end
        end
        wr_en = 1'b1; wr_data = d; wr_brk = b; wr_frm = f; wr_par = p;
        @(negedge clk);
        wr_en = 1'b0; wr_brk = 1'b0; wr_frm = 1'b0; wr_par = 1'b0;
    endtask

    // Monitor: compare head tag then data with the scoreboard, then pop.
    task automatic take(input string req);
        logic [11:0] e;
        e = sb.pop_front();
        check({req, " head_err"}, int'(head_err), int'(e[11:8]));
        check({req, " head_data"}, int'(head_data), int'(e[7:0]));
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            bit_tick = 1'b1;
            @(negedge clk);
            bit_tick = 1'b0;
        end
    endtask

    task automatic clear(input logic [2:0] m);
        clr_irq = m;
        @(negedge clk);
        clr_irq = 3'b000;
    endtask

    task automatic flush_model();
        sb.delete();
        pend = 1'b0;
    endtask

    function automatic int held();
        return int'({stat_full, stat_cnt});
    endfunction

    logic done = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state
        check("R11 count", held(), 0);
        check("R11 irqs", int'({irq_rx, irq_err, irq_tout}), 0);

        // R2 R3 R6: tagged entries in order
        put(8'hA1, 1'b0, 1'b0, 1'b1);
        check("R6 irq_err after parity tag", int'(irq_err), 1);
        put(8'hB2, 1'b1, 1'b0, 1'b0);
        put(8'hC3, 1'b0, 1'b1, 1'b0);
        check("R1 count three", held(), 3);
        take("R3 parity");
        take("R3 break");
        take("R3 framing");
        clear(3'b111);
        check("R8 irq_err cleared", int'(irq_err), 0);
        pop = 1'b1; idle(); pop = 1'b0;
        check("R2 pop on empty", held(), 0);

        // R5: trigger level 8 then 4
        trig_sel = 2'd1;
        for (int i = 0; i < 7; i++) put(8'(i), 1'b0, 1'b0, 1'b0);
        idle();
        check("R5 below level 8", int'(irq_rx), 0);
        put(8'h07, 1'b0, 1'b0, 1'b0);
        idle();
        check("R5 at level 8", int'(irq_rx), 1);
        clear(3'b001);
        check("R8 set wins over clear", int'(irq_rx), 1);
        take("R2 first of eight");
        clear(3'b001);
        check("R8 clear after level drop", int'(irq_rx), 0);
        while (sb.size() > 4) take("R2 drain");
        trig_sel = 2'd0;
        idle();
        check("R5 level 4 at four", int'(irq_rx), 1);
        while (sb.size() > 0) take("R2 drain");
        clear(3'b111);
        trig_sel = 2'd3;

        // R1 R4: full, overflow, pending overrun
        for (int i = 0; i < 16; i++) put(8'h40 + 8'(i), 1'b0, 1'b0, 1'b0);
        check("R1 full flag", int'(stat_full), 1);
        check("R1 count field zero when full", int'(stat_cnt), 0);
        put(8'hEE, 1'b0, 1'b0, 1'b0);
        check("R4 still full after overflow", held(), 16);
        take("R4 head after overflow");
        while (sb.size() > 0) take("R4 drain");
        put(8'h5A, 1'b0, 1'b0, 1'b0);
        check("R4 overrun sets irq_err", int'(irq_err), 1);
        take("R4 overrun tagged");
        clear(3'b111);

        // R7: timeout with empty queue, restart on write
        rx_idle = 1'b1;
        tick(31);
        check("R7 no timeout at 31", int'(irq_tout), 0);
        tick(1);
        check("R7 timeout at 32 empty", int'(irq_tout), 1);
        clear(3'b100);
        put(8'h11, 1'b0, 1'b0, 1'b0);
        tick(20);
        put(8'h12, 1'b0, 1'b0, 1'b0);
        tick(20);
        check("R7 restart on write", int'(irq_tout), 0);
        tick(12);
        check("R7 timeout after restart", int'(irq_tout), 1);
        take("R7 entry");
        clear(3'b111);

        // R9: clear drops entries and pending overrun
        for (int i = 0; i < 17; i++) put(8'h60 + 8'(i), 1'b0, 1'b0, 1'b0);
        fifo_clr = 1'b1; idle(); fifo_clr = 1'b0;
        flush_model();
        check("R9 empty after clear", held(), 0);
        put(8'h77, 1'b0, 1'b0, 1'b0);
        take("R9 no stale overrun");
        clear(3'b111);

        // R10: disable empties, ignores writes, stops the timer
        put(8'h81, 1'b0, 1'b0, 1'b0);
        put(8'h82, 1'b0, 1'b0, 1'b0);
        rx_enable = 1'b0;
        idle();
        flush_model();
        check("R10 empty on disable", held(), 0);
        put(8'h83, 1'b1, 1'b0, 1'b0);
        check("R10 write ignored", held(), 0);
        check("R10 no err flag", int'(irq_err), 0);
        tick(40);
        check("R10 timer held", int'(irq_tout), 0);
        rx_enable = 1'b1;
        rx_idle = 1'b0;
        idle();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule